// File: doc/BRIEF.md
# Detector Status Collector with Change Interrupt

This block gathers six asynchronous flags from a modem's line detectors into one registered status byte that a host can read. Each flag is brought into the clock domain by its own two-stage synchroniser and then captured in a status stage. A flag's new value is visible one clock after it leaves the synchroniser.

When enabled, the block watches four of the flags: call progress, answer tone, carrier and unscrambled mark. A change in either direction on any of them raises an active-low interrupt. The interrupt stays asserted until the host reads the status byte. Masking depends on context. Answer tone and call progress changes are ignored while the local transmitter is enabled. Carrier changes are ignored while dual-tone dialling is being sent. Nothing raises an interrupt while the device is powered down.

A change that arrives while its mask is active is simply lost. Lifting the mask later does not raise it.

Top module: `det_status_irq`

## Requirements
- R1: After a synchronous active-low reset, `stat_q` reads 0 and `irq_n` is 1.
- R2: `stat_q` bit 0 mirrors the low-signal (long loop) detector and bit 1 mirrors the call-progress detector.
- R3: `stat_q` bits 2, 3, 4 and 5 mirror, in that order, answer tone, carrier, unscrambled mark and received data; bits 7 and 6 read 0.
- R4: While `irq_en` is 0, `irq_n` stays 1 whatever the flags do, and any pending interrupt is dropped.
- R5: With `irq_en` at 1 and no mask active, a rising or a falling change of `det_raw` bit 1, 2, 3 or 4 drives `irq_n` to 0; changes of bit 0 or bit 5 never do.
- R6: While `tx_en` is 1, changes of bits 1 and 2 raise no interrupt.
- R7: While `dtmf_tx` is 1, changes of bit 3 raise no interrupt.
- R8: While `pwr_down` is 1, no change raises an interrupt and a pending interrupt is dropped.
- R9: Once asserted, `irq_n` stays 0 until a cycle with `stat_rd` at 1. It returns to 1 on the following edge, unless a new unmasked change arrives in that same cycle.
- R10: A change that happens while masked does not assert `irq_n` when the mask is later lifted.
- R11: A change on `det_raw` applied before clock edge k appears on `stat_q`, and `irq_n` may fall, after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| det_raw | input | 6 | Asynchronous detector flags |
| irq_en | input | 1 | Interrupt enable |
| tx_en | input | 1 | Transmitter enabled; masks answer tone and call progress |
| dtmf_tx | input | 1 | Dual-tone transmission active; masks carrier |
| pwr_down | input | 1 | Power-down; suppresses all interrupts |
| stat_rd | input | 1 | One-cycle strobe: host reads the status byte |
| stat_q | output | 8 | Registered detector status byte |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench toggles every one of the six flags twice, once rising and once falling, under all sixteen combinations of enable, transmit, dual-tone and power-down. This separates the watched bits from the unwatched ones and shows each mask acting only on its own bits. Each case also checks that the interrupt holds until a read and then clears. Separate sequences fix the three-edge latency, lift a mask after a hidden change to confirm nothing is deferred, and enter power-down with an interrupt pending.

// File: rtl/det_status_pkg.sv
// Package: shared widths, status bit positions and the interrupt source
// mask rule for the detector status collector.
// Assumes six detector flags and an eight-bit status byte.
package det_status_pkg;

    localparam int DET_N  = 6;
    localparam int STAT_W = 8;

    localparam int B_LOOP  = 0;
    localparam int B_CPROG = 1;
    localparam int B_ANS   = 2;
    localparam int B_CARR  = 3;
    localparam int B_UMARK = 4;
    localparam int B_RXD   = 5;

    // Which flag changes may raise an interrupt in the given context.
    function automatic logic [DET_N-1:0] irq_source_mask(input logic tx_on,
                                                         input logic dtmf_on);
        logic [DET_N-1:0] m;
        m          = '0;
        m[B_CPROG] = ~tx_on;
        m[B_ANS]   = ~tx_on;
        m[B_CARR]  = ~dtmf_on;
        m[B_UMARK] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/det_sync.sv
// Module: det_sync
// Two-flop synchroniser, one chain per bit. Assumes each input bit is an
// independent level and that a two-cycle settling delay is acceptable.
module det_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1;
        logic s2;

        // Shift the raw level through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_async[i];
                s2 <= s1;
            end
        end

        assign d_sync[i] = s2;
    end

endmodule

// File: rtl/det_edge.sv
// Module: det_edge
// Holds the current status vector and flags every bit whose synchronised
// value differs from the held one. Assumes the input is already synchronous.
module det_edge #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    output logic [W-1:0] held,
    output logic [W-1:0] chg
);

    // Capture the synchronised flags as the visible status.
    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else        held <= cur;
    end

    assign chg = cur ^ held;

    // R2 R3: held status tracks the synchronised flags one cycle later
    p_status_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> held == $past(cur));

endmodule

// File: rtl/det_irq_ctl.sv
// Module: det_irq_ctl
// Turns masked flag changes into a sticky interrupt, cleared by a status
// read, by the enable dropping, or by power-down. Assumes chg is valid for
// the cycle in which the status register takes the new value.
module det_irq_ctl
    import det_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DET_N-1:0] chg,
    input  logic             irq_en,
    input  logic             tx_en,
    input  logic             dtmf_tx,
    input  logic             pwr_down,
    input  logic             stat_rd,
    output logic             irq_n
);

    logic [DET_N-1:0] src_ok;
    logic             set_evt;
    logic             pend;

    // Decide which changes count in this cycle's context.
    always_comb begin
        src_ok  = irq_source_mask(tx_en, dtmf_tx);
        set_evt = (|(chg & src_ok)) & irq_en & ~pwr_down;
    end

    // Sticky interrupt: set by an event, cleared by read, enable or power.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pend <= 1'b0;
        else if (!irq_en || pwr_down) pend <= 1'b0;
        else if (set_evt)            pend <= 1'b1;
        else if (stat_rd)            pend <= 1'b0;
    end

    assign irq_n = ~pend;

    // R4: disabled interrupt leaves the pin high next cycle
    p_en_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> irq_n);

    // R8: power-down leaves the pin high next cycle
    p_pwr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> irq_n);

    // R9: a read with no fresh event releases the pin
    p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !set_evt) |=> irq_n);

    // R9: the pin only stays low while no read is seen
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !stat_rd && irq_en && !pwr_down) |=> !irq_n);

    // R5 R10: a falling pin always has an unmasked change behind it
    p_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(set_evt));

endmodule

// File: rtl/det_status_irq.sv
// Module: det_status_irq
// Top: synchronises six detector flags, presents them as a status byte and
// drives an active-low change interrupt with context masking.
// Assumes stat_rd is a single-cycle strobe from the host interface.
module det_status_irq
    import det_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DET_N-1:0]  det_raw,
    input  logic              irq_en,
    input  logic              tx_en,
    input  logic              dtmf_tx,
    input  logic              pwr_down,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_q,
    output logic              irq_n
);

    localparam int PAD_W = STAT_W - DET_N;

    logic [DET_N-1:0] det_s;
    logic [DET_N-1:0] det_held;
    logic [DET_N-1:0] det_chg;

    det_sync #(.W(DET_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (det_raw),
        .d_sync  (det_s)
    );

    det_edge #(.W(DET_N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (det_s),
        .held  (det_held),
        .chg   (det_chg)
    );

    det_irq_ctl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .chg      (det_chg),
        .irq_en   (irq_en),
        .tx_en    (tx_en),
        .dtmf_tx  (dtmf_tx),
        .pwr_down (pwr_down),
        .stat_rd  (stat_rd),
        .irq_n    (irq_n)
    );

    assign stat_q = {{PAD_W{1'b0}}, det_held};

    // R3: unused upper status bits read zero
    always_comb begin
        p_pad_zero_r3: assert (stat_q[STAT_W-1:DET_N] == '0);
    end

endmodule

// File: tb/test_det_status_irq.sv
// Bench: sweeps every flag in both directions under every context.
module test_det_status_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] det_raw = '0;
    logic       irq_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       dtmf_tx = 1'b0;
    logic       pwr_down = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_q;
    logic       irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    det_status_irq i_det_status_irq (
        .clk (clk), .rst_n (rst_n), .det_raw (det_raw), .irq_en (irq_en),
        .tx_en (tx_en), .dtmf_tx (dtmf_tx), .pwr_down (pwr_down),
        .stat_rd (stat_rd), .stat_q (stat_q), .irq_n (irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd_pulse();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
        #1;
    endtask

    task automatic flip(input int b);
        @(negedge clk) det_raw[b] = ~det_raw[b];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(4);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1 stat", stat_q, 8'h00);
        chk("R1 irq", {7'd0, irq_n}, 8'h01);

        // Full sweep: every context, every flag, rising then falling.
        for (int ctx = 0; ctx < 16; ctx++) begin
            for (int b = 0; b < 6; b++) begin
                for (int rep = 0; rep < 2; rep++) begin
                    logic en, tx, dt, pd, want;
                    string tag;
                    en = ctx[0]; tx = ctx[1]; dt = ctx[2]; pd = ctx[3];
                    @(negedge clk);
                    irq_en = en; tx_en = tx; dtmf_tx = dt; pwr_down = pd;
                    rd_pulse();
                    want = en && !pd && (b >= 1 && b <= 4)
                           && !(tx && (b == 1 || b == 2)) && !(dt && b == 3);
                    if (!en)                          tag = "R4";
                    else if (pd)                      tag = "R8";
                    else if (tx && (b == 1 || b == 2)) tag = "R6";
                    else if (dt && b == 3)            tag = "R7";
                    else                              tag = "R5";
                    flip(b);
                    cyc(3);
                    chk(b < 2 ? "R2 bit map" : "R3 bit map", stat_q, {2'b00, det_raw});
                    chk(tag, {7'd0, irq_n}, {7'd0, ~want});
                    if (want) begin
                        cyc(2);
                        chk("R9 hold", {7'd0, irq_n}, 8'h00);
                        rd_pulse();
                        chk("R9 clear", {7'd0, irq_n}, 8'h01);
                    end
                end
            end
        end

        // Latency: visible after the third edge, not the second.
        @(negedge clk);
        irq_en = 1; tx_en = 0; dtmf_tx = 0; pwr_down = 0;
        rd_pulse();
        flip(3);
        cyc(2);
        chk("R11 early stat", stat_q, {2'b00, det_raw ^ 6'b001000});
        chk("R11 early irq", {7'd0, irq_n}, 8'h01);
        cyc(1);
        chk("R11 stat", stat_q, {2'b00, det_raw});
        chk("R11 irq", {7'd0, irq_n}, 8'h00);
        rd_pulse();

        // No deferred interrupt after the mask is lifted.
        @(negedge clk) tx_en = 1;
        flip(2);
        cyc(4);
        @(negedge clk) tx_en = 0;
        cyc(4);
        chk("R10 no deferred", {7'd0, irq_n}, 8'h01);

        // Power-down drops a pending interrupt.
        flip(4);
        cyc(3);
        chk("R8 pending set", {7'd0, irq_n}, 8'h00);
        @(negedge clk) pwr_down = 1;
        cyc(1);
        chk("R8 pending dropped", {7'd0, irq_n}, 8'h01);
        @(negedge clk) pwr_down = 0;
        cyc(2);
        chk("R8 stays clear", {7'd0, irq_n}, 8'h01);

        // Disabling drops a pending interrupt.
        flip(1);
        cyc(3);
        chk("R4 pending set", {7'd0, irq_n}, 8'h00);
        @(negedge clk) irq_en = 0;
        cyc(1);
        chk("R4 pending dropped", {7'd0, irq_n}, 8'h01);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule